// File: doc/BRIEF.md
# Reset Sequencer with Boot-Strap Sampling

This block is the chip-level reset controller. It collects three reset sources and sequences a single internal chip reset from them. The sources are a supply that is not yet good, an internal request such as a watchdog bite, and a low level on the shared open-drain reset pad. Every sequence pulls the pad low for a guaranteed minimum number of clock cycles. Because the pad is read back as an input, the pull-down the block applies keeps its own reset alive. When an outside driver holds the pad down for longer, that driver decides when the sequence ends.

The chip reset ends only when the synchronized pad level has read high on consecutive cycles. In that same cycle the block captures the synchronized boot-strap input. A low strap selects the flash-programming port mode, and a high strap selects normal CPU boot. The selected mode and a code naming the cause of the last reset stay fixed until the next sequence starts. Supply-good low acts as the power-on source and is the only source that waits on the supply. The internal and external sources skip that wait and otherwise follow the same steps.

Top module: `rsq_top`

## Requirements
- R1: While `supply_ok` is low, `pad_pull_dn` and `chip_rst` are 1, `boot_prog` is 0 and `rst_cause` is 2'd1 (power-on). This applies whatever the other inputs are. Once `supply_ok` rises, the pull-down lasts 128 clock cycles, counting the first cycle in which `supply_ok` is high.
- R2: Every reset sequence drives `pad_pull_dn` high for at least `STRETCH_CYC` (default 128) consecutive cycles. A short external low pulse on the pad still produces the full stretch.
- R3: `chip_rst` is 1 in every cycle in which `pad_pull_dn` is 1. Internal and external entries raise both outputs in the same cycle.
- R4: The pad input passes through a 2-flop synchronizer and must read high on 2 consecutive synchronized cycles. `chip_rst` therefore falls on the 4th clock edge after the pad goes high. With no outside holder, a sequence keeps `chip_rst` high for `STRETCH_CYC`+4 cycles.
- R5: A low pad level seen while the chip is running starts a sequence with cause 2'd3 (external), 3 edges after the pad falls. `chip_rst` stays high for as long as the outside driver holds the pad low, after the block's own pull-down has ended.
- R6: In the release cycle, `boot_prog` is loaded with the inverse of the synchronized strap (strap low gives 1, programming mode). Strap changes at any other time do not change `boot_prog`.
- R7: `rst_cause` codes are 1 power-on, 2 internal and 3 external. It changes only when a sequence starts or during one, and it holds while the chip runs. Power-on beats internal, and internal beats external, when they arrive in the same cycle.
- R8: A `wdog_req` sampled during the stretch restarts it, so the pull-down ends `STRETCH_CYC` cycles after the last request. A request sampled while waiting for the pad returns the block to a full stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| supply_ok | input | 1 | Supply good; low is the power-on reset source and resets the block synchronously |
| wdog_req | input | 1 | Internal reset request, sampled each cycle |
| pad_in | input | 1 | Level read back from the shared reset pad |
| strap_in | input | 1 | Boot-mode strap, asynchronous |
| pad_pull_dn | output | 1 | Enable of the pad pull-down driver |
| chip_rst | output | 1 | Internal chip reset, active high |
| boot_prog | output | 1 | Latched mode: 1 programming port, 0 normal CPU boot |
| rst_cause | output | 2 | Cause of the last sequence: 1 power-on, 2 internal, 3 external |

## Verification
An internal request and the detection of a low pad on the reset line can fall in the same running cycle. The bench provokes this by pulling the pad low from outside and timing a one-cycle request to the third edge afterwards, which is the edge where the synchronized pad first reads low. The result is judged by the cause code, which must read internal. The release timing must still follow the outside holder: chip reset lasts the hold length plus one cycle. A second overlap, power-on arriving with a request held high, must report power-on.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    ST_STRETCH = 2'd0,
    ST_RELWAIT = 2'd1,
    ST_RUN     = 2'd2
  } rsq_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_POR  = 2'd1,
    CAUSE_INT  = 2'd2,
    CAUSE_EXT  = 2'd3
  } rsq_cause_e;

endpackage

// File: rtl/rsq_sync.sv
// Multi-stage synchronizer for a small bundle of asynchronous inputs.
module rsq_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/rsq_stretch.sv
// Minimum pull-down stretch counter; a restart puts it back to zero.
module rsq_stretch #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic last
);

  localparam int            CW       = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (cnt != LAST_VAL)   cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == LAST_VAL);

endmodule

// File: rtl/rsq_release.sv
// Release filter: the synchronized pad must read high NEED cycles in a row.
module rsq_release #(
  parameter int NEED = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic level,
  output logic done
);

  localparam int            CW       = (NEED > 1) ? $clog2(NEED) : 1;
  localparam logic [CW-1:0] LAST_HIT = CW'(NEED - 1);

  logic [CW-1:0] hits;

  always_ff @(posedge clk) begin
    if (rst || !arm || !level) hits <= '0;
    else if (hits != LAST_HIT) hits <= hits + 1'b1;
  end

  assign done = arm && level && (hits == LAST_HIT);

endmodule

// File: rtl/rsq_top.sv
module rsq_top #(
  parameter int STRETCH_CYC = 128,
  parameter int SYNC_STAGES = 2,
  parameter int REL_HITS    = 2
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       wdog_req,
  input  logic       pad_in,
  input  logic       strap_in,
  output logic       pad_pull_dn,
  output logic       chip_rst,
  output logic       boot_prog,
  output logic [1:0] rst_cause
);
  import rsq_pkg::*;

  // bit 1: strap (idles high = normal boot), bit 0: pad (idles low = in reset)
  localparam logic [1:0] SYNC_RST = 2'b10;

  logic       por_rst;
  logic [1:0] sync_q;
  logic       pad_s;
  logic       strap_s;
  logic       stretch_last;
  logic       rel_done;

  rsq_state_e state_q;
  rsq_cause_e cause_q;
  logic       pull_q;
  logic       chip_q;
  logic       boot_q;

  assign por_rst = !supply_ok;

  rsq_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(por_rst),
    .d  ({strap_in, pad_in}),
    .q  (sync_q)
  );

  assign pad_s   = sync_q[0];
  assign strap_s = sync_q[1];

  rsq_stretch #(
    .LEN(STRETCH_CYC)
  ) u_stretch (
    .clk    (clk),
    .rst    (por_rst),
    .run    (state_q == ST_STRETCH),
    .restart(wdog_req),
    .last   (stretch_last)
  );

  rsq_release #(
    .NEED(REL_HITS)
  ) u_release (
    .clk  (clk),
    .rst  (por_rst),
    .arm  (state_q == ST_RELWAIT),
    .level(pad_s),
    .done (rel_done)
  );

  always_ff @(posedge clk) begin
    if (por_rst) begin
      state_q <= ST_STRETCH;
      cause_q <= CAUSE_POR;
      pull_q  <= 1'b1;
      chip_q  <= 1'b1;
      boot_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_STRETCH: begin
          if (wdog_req) begin
            cause_q <= CAUSE_INT;
          end else if (stretch_last) begin
            state_q <= ST_RELWAIT;
            pull_q  <= 1'b0;
          end
        end
        ST_RELWAIT: begin
          if (wdog_req) begin
            state_q <= ST_STRETCH;
            cause_q <= CAUSE_INT;
            pull_q  <= 1'b1;
          end else if (rel_done) begin
            state_q <= ST_RUN;
            chip_q  <= 1'b0;
            boot_q  <= !strap_s;
          end
        end
        ST_RUN: begin
          if (wdog_req) begin
            state_q <= ST_STRETCH;
            cause_q <= CAUSE_INT;
            pull_q  <= 1'b1;
            chip_q  <= 1'b1;
          end else if (!pad_s) begin
            state_q <= ST_STRETCH;
            cause_q <= CAUSE_EXT;
            pull_q  <= 1'b1;
            chip_q  <= 1'b1;
          end
        end
        default: begin
          state_q <= ST_STRETCH;
          pull_q  <= 1'b1;
          chip_q  <= 1'b1;
        end
      endcase
    end
  end

  assign pad_pull_dn = pull_q;
  assign chip_rst    = chip_q;
  assign boot_prog   = boot_q;
  assign rst_cause   = cause_q;

endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
  parameter int STRETCH_CYC = 128
) (
  input logic       clk,
  input logic       supply_ok,
  input logic       wdog_req,
  input logic       pad_in,
  input logic       pad_pull_dn,
  input logic       chip_rst,
  input logic       boot_prog,
  input logic [1:0] rst_cause
);

  localparam int            RW      = $clog2(STRETCH_CYC + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STRETCH_CYC);

  logic [RW-1:0] pd_run;

  always_ff @(posedge clk) begin
    if (!supply_ok || !pad_pull_dn) pd_run <= '0;
    else if (pd_run != RUN_MAX)     pd_run <= pd_run + 1'b1;
  end

  AST_PULL_MIN_LEN: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(pad_pull_dn) |-> (pd_run == RUN_MAX)); // R2

  AST_PULL_IMPLIES_RST: assert property (@(posedge clk) disable iff (!supply_ok)
    pad_pull_dn |-> chip_rst); // R3

  AST_RELEASE_PAD_HIGH: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(chip_rst) |-> ($past(pad_in, 3) && $past(pad_in, 4))); // R4

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!supply_ok)
    !$fell(chip_rst) |-> $stable(boot_prog)); // R6

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!supply_ok)
    (!chip_rst && $past(!chip_rst)) |-> $stable(rst_cause)); // R7

  AST_REQ_ENTRY: assert property (@(posedge clk) disable iff (!supply_ok)
    (wdog_req && !chip_rst) |=> (pad_pull_dn && chip_rst && rst_cause == 2'd2)); // R8

endmodule

bind rsq_top rsq_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk        (clk),
  .supply_ok  (supply_ok),
  .wdog_req   (wdog_req),
  .pad_in     (pad_in),
  .pad_pull_dn(pad_pull_dn),
  .chip_rst   (chip_rst),
  .boot_prog  (boot_prog),
  .rst_cause  (rst_cause)
);

// File: tb/sim_rsq_top.sv
module sim_rsq_top;

  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 128;
  localparam int SEQ_LEN    = STRETCH + 4;

  logic       clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic       wdog_req = 1'b0;
  logic       ext_hold = 1'b0;
  logic       strap_in = 1'b1;
  logic       pad_in;
  logic       pad_pull_dn;
  logic       chip_rst;
  logic       boot_prog;
  logic [1:0] rst_cause;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // open-drain pad: wired-AND of both pull-downs with a pull-up
  assign pad_in = ~(pad_pull_dn | ext_hold);

  rsq_top #(.STRETCH_CYC(STRETCH)) u0 (
    .clk        (clk),
    .supply_ok  (supply_ok),
    .wdog_req   (wdog_req),
    .pad_in     (pad_in),
    .strap_in   (strap_in),
    .pad_pull_dn(pad_pull_dn),
    .chip_rst   (chip_rst),
    .boot_prog  (boot_prog),
    .rst_cause  (rst_cause)
  );

  typedef struct {
    int         rst_len;
    string      rq_len;
    int         pd_len;
    string      rq_pd;
    logic [1:0] cause;
    logic       boot;
  } exp_t;

  exp_t sb[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_release();
    do @(negedge clk); while (chip_rst);
    cyc(5);
  endtask

  task automatic push(input int rl, input string rql, input int pl, input string rqp,
                      input logic [1:0] c, input logic b);
    exp_t e;
    e.rst_len = rl; e.rq_len = rql; e.pd_len = pl; e.rq_pd = rqp;
    e.cause = c; e.boot = b;
    sb.push_back(e);
  endtask

  // monitor: measures each sequence and compares against the scoreboard
  int rst_run = 0;
  int pd_run  = 0;
  int pd_last = 0;
  bit r3_bad  = 1'b0;

  always @(negedge clk) begin
    if (!supply_ok) begin
      rst_run = 0;
      pd_run  = 0;
    end else begin
      if (pad_pull_dn && !chip_rst) r3_bad = 1'b1;
      if (pad_pull_dn) pd_run++;
      else if (pd_run > 0) begin
        pd_last = pd_run;
        pd_run  = 0;
      end
      if (chip_rst) rst_run++;
      else if (rst_run > 0) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R4", "release with no expected sequence", rst_run, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rst_run == e.rst_len, e.rq_len, "chip_rst length", rst_run, e.rst_len);
          chk(pd_last == e.pd_len, e.rq_pd, "pull-down length", pd_last, e.pd_len);
          chk(rst_cause == e.cause, "R7", "cause code", rst_cause, e.cause);
          chk(boot_prog == e.boot, "R6", "boot mode", boot_prog, e.boot);
        end
        rst_run = 0;
      end
    end
  end

  initial begin
    // R1: state while supply is not good
    cyc(4);
    wdog_req = 1'b1;
    cyc(1);
    @(negedge clk);
    chk(pad_pull_dn == 1'b1, "R1", "pull-down in power-on", pad_pull_dn, 1);
    chk(chip_rst == 1'b1, "R1", "chip_rst in power-on", chip_rst, 1);
    chk(rst_cause == 2'd1, "R1", "cause in power-on", rst_cause, 1);
    chk(boot_prog == 1'b0, "R1", "boot in power-on", boot_prog, 0);
    cyc(1);
    wdog_req = 1'b0;
    push(SEQ_LEN, "R4", STRETCH, "R1", 2'd1, 1'b0);
    supply_ok = 1'b1;
    wait_release();

    // R8: internal request, plain
    push(SEQ_LEN, "R4", STRETCH, "R2", 2'd2, 1'b0);
    wdog_req = 1'b1; cyc(1); wdog_req = 1'b0;
    wait_release();

    // R8: second request 50 cycles into the stretch restarts it
    push(SEQ_LEN + 50, "R8", STRETCH + 50, "R8", 2'd2, 1'b0);
    wdog_req = 1'b1; cyc(1); wdog_req = 1'b0;
    cyc(49);
    wdog_req = 1'b1; cyc(1); wdog_req = 1'b0;
    wait_release();

    // R5/R6: long external hold with strap low selects programming mode
    strap_in = 1'b0;
    cyc(5);
    push(401, "R5", STRETCH, "R2", 2'd3, 1'b1);
    ext_hold = 1'b1;
    cyc(300);
    @(negedge clk);
    chk(chip_rst == 1'b1, "R5", "chip_rst while pad held", chip_rst, 1);
    chk(pad_pull_dn == 1'b0, "R5", "own pull-down ended", pad_pull_dn, 0);
    cyc(100);
    ext_hold = 1'b0;
    wait_release();
    strap_in = 1'b1;
    cyc(20);
    @(negedge clk);
    chk(boot_prog == 1'b1, "R6", "strap change after release ignored", boot_prog, 1);
    chk(rst_cause == 2'd3, "R7", "cause held while running", rst_cause, 3);
    cyc(1);

    // R2: short external pulse is stretched by the block's own pull-down
    push(SEQ_LEN, "R4", STRETCH, "R2", 2'd3, 1'b0);
    ext_hold = 1'b1; cyc(10); ext_hold = 1'b0;
    wait_release();

    // R7: internal request in the same cycle as the external detection
    push(401, "R5", STRETCH, "R2", 2'd2, 1'b0);
    ext_hold = 1'b1;
    cyc(2);
    wdog_req = 1'b1; cyc(1); wdog_req = 1'b0;
    cyc(397);
    ext_hold = 1'b0;
    wait_release();

    // R7: power-on together with a held request reports power-on
    supply_ok = 1'b0;
    wdog_req  = 1'b1;
    cyc(5);
    push(SEQ_LEN, "R4", STRETCH, "R1", 2'd1, 1'b0);
    supply_ok = 1'b1;
    wdog_req  = 1'b0;
    wait_release();

    chk(r3_bad == 1'b0, "R3", "pull-down seen without chip_rst", r3_bad, 0);
    chk(sb.size() == 0, "R4", "sequences left unreleased", sb.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R4", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule